// File: doc/BRIEF.md
# OTG Power-Down and Wake Sequencer

This block decides when a battery-powered dual-role USB controller may sleep and how it comes back. It runs from a slow clock that never stops. When no session is active, it first holds the host and device controllers in suspend. In the next cycle it switches off the PLL, the oscillator and the VBUS charge pump. While asleep it watches a set of OTG event lines, such as VBUS comparators, ID detect and line activity. These lines are asynchronous, so each passes through two flip-flops and a change detector. A change in either direction on any line restarts the clocks. A software wake request restarts them as well, even when no event has occurred.

After a wake, the sequencer keeps the controllers suspended until the synchronised clock-stable input goes high. It then releases suspend and, if the interrupt is enabled, raises a one-cycle wake interrupt. If the clock does not report stable within a programmable number of slow-clock cycles, the wake is abandoned and the block returns to sleep.

The states are RUN, ENTER_PD, POWER_DOWN, WAIT_CLK and RESUME. The transitions are:
- RUN→ENTER_PD when the session is inactive.
- ENTER_PD→POWER_DOWN unconditionally.
- POWER_DOWN→WAIT_CLK on an event change or a software wake.
- WAIT_CLK→RESUME when the clock is stable.
- WAIT_CLK→POWER_DOWN on timeout.
- RESUME→RUN unconditionally.

Top module: `otg_pwr_sequencer`

## Requirements
- R1: After reset the block is in RUN: both suspends are low, pll_en, osc_en and cp_en are high, and wake_irq is low.
- R2: In RUN with session_active low, after the next edge both suspends are high and all three enables are still high (ENTER_PD). One edge later all three enables are low.
- R3: In POWER_DOWN, both suspends are high and pll_en, osc_en and cp_en are low. These values hold for as long as no wake cause appears; session_active has no effect in this state.
- R4: In POWER_DOWN, a change of either polarity on any otg_evt bit moves the block to WAIT_CLK on the third rising edge after the change. In WAIT_CLK, pll_en and osc_en are high, cp_en is low and both suspends stay high.
- R5: In POWER_DOWN, sw_wake sampled high at an edge moves the block to WAIT_CLK at that edge.
- R6: Suspends are released only after clk_stable is seen. A rise of clk_stable during WAIT_CLK enters RESUME on the third following edge, with suspends low and all enables high. The next edge enters RUN.
- R7: wake_irq is high for exactly the one RESUME cycle, and only when wake_irq_en is high.
- R8: If clk_stable is not seen, WAIT_CLK lasts exactly max(stable_timeout,1) cycles and then returns to POWER_DOWN without any interrupt. A stable indication wins over a timeout in the same cycle.
- R9: Event changes and sw_wake outside POWER_DOWN have no effect. An event line held at a constant level does not wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| session_active | input | 1 | High while a USB session is in progress |
| otg_evt | input | N_EVT | Asynchronous OTG event lines |
| sw_wake | input | 1 | Software wake request, synchronous to clk_slow |
| clk_stable | input | 1 | Asynchronous PLL/oscillator lock indication |
| wake_irq_en | input | 1 | Enables the wake interrupt |
| stable_timeout | input | CNT_W | Maximum WAIT_CLK length in slow cycles |
| hc_suspend | output | 1 | Host controller suspend |
| dc_suspend | output | 1 | Device controller suspend |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| cp_en | output | 1 | VBUS charge pump enable |
| wake_irq | output | 1 | One-cycle wake interrupt |

## Verification
The hardest case to reach is the abandoned wake. Here the clock never reports stable, and the timer must return the block to sleep after an exact number of cycles. The stimulus covers this by holding clk_stable low, issuing a software wake and sweeping stable_timeout over 0 to 6. For each value the bench counts the cycles during which pll_en stays high. The event path is covered by a sweep over every event bit, both edge directions and both interrupt-enable settings. Each wake in that sweep needs the stale event level left by the previous run, so the bench also checks that a held level does not re-trigger a wake.

// File: rtl/otg_pwr_pkg.sv
package otg_pwr_pkg;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_ENTER_PD   = 3'd1,
        ST_POWER_DOWN = 3'd2,
        ST_WAIT_CLK   = 3'd3,
        ST_RESUME     = 3'd4
    } pwr_state_t;

endpackage

// File: rtl/otg_sync2.sv
// Two-flop synchroniser, one chain per bit.
module otg_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                sync_q <= meta_q;
            end
        end
        assign sync_out[g] = sync_q;
    end
endmodule

// File: rtl/otg_chg_det.sv
// Flags a level change of either polarity on any synchronised line.
module otg_chg_det #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic             any_change
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_diff
        assign diff[g] = level[g] ^ prev_q[g];
    end

    assign any_change = |diff;
endmodule

// File: rtl/otg_wait_timer.sv
// Counts cycles while run is high; expired marks the last allowed cycle.
module otg_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_plus;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run)           cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_plus = {1'b0, cnt_q} + 1'b1;
    assign expired  = run && (cnt_plus >= {1'b0, limit});
endmodule

// File: rtl/otg_pwr_fsm.sv
module otg_pwr_fsm
    import otg_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       session_active,
    input  logic       evt_change,
    input  logic       sw_wake,
    input  logic       clk_ok,
    input  logic       wait_expired,
    input  logic       irq_en,
    output logic       in_wait,
    output logic       suspend,
    output logic       pll_on,
    output logic       osc_on,
    output logic       cp_on,
    output logic       irq
);
    pwr_state_t state_q;
    pwr_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:        if (!session_active)         state_d = ST_ENTER_PD;
            ST_ENTER_PD:                                state_d = ST_POWER_DOWN;
            ST_POWER_DOWN: if (evt_change || sw_wake)   state_d = ST_WAIT_CLK;
            ST_WAIT_CLK: begin
                if (clk_ok)            state_d = ST_RESUME;
                else if (wait_expired) state_d = ST_POWER_DOWN;
            end
            ST_RESUME:                                  state_d = ST_RUN;
            default:                                    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        suspend = 1'b0;
        pll_on  = 1'b1;
        osc_on  = 1'b1;
        cp_on   = 1'b1;
        irq     = 1'b0;
        in_wait = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_ENTER_PD: suspend = 1'b1;
            ST_POWER_DOWN: begin
                suspend = 1'b1;
                pll_on  = 1'b0;
                osc_on  = 1'b0;
                cp_on   = 1'b0;
            end
            ST_WAIT_CLK: begin
                suspend = 1'b1;
                cp_on   = 1'b0;
                in_wait = 1'b1;
            end
            ST_RESUME: irq = irq_en;
            default: ;
        endcase
    end
endmodule

// File: rtl/otg_pwr_sequencer.sv
module otg_pwr_sequencer #(
    parameter int N_EVT = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic             session_active,
    input  logic [N_EVT-1:0] otg_evt,
    input  logic             sw_wake,
    input  logic             clk_stable,
    input  logic             wake_irq_en,
    input  logic [CNT_W-1:0] stable_timeout,
    output logic             hc_suspend,
    output logic             dc_suspend,
    output logic             pll_en,
    output logic             osc_en,
    output logic             cp_en,
    output logic             wake_irq
);
    logic [N_EVT-1:0] evt_sync;
    logic             evt_change;
    logic             stable_sync;
    logic             in_wait;
    logic             wait_expired;
    logic             suspend;

    otg_sync2 #(.WIDTH(N_EVT)) u_evt_sync (
        .clk      (clk_slow),
        .rst_n    (rst_n),
        .async_in (otg_evt),
        .sync_out (evt_sync)
    );

    otg_chg_det #(.WIDTH(N_EVT)) u_evt_chg (
        .clk        (clk_slow),
        .rst_n      (rst_n),
        .level      (evt_sync),
        .any_change (evt_change)
    );

    otg_sync2 #(.WIDTH(1)) u_stable_sync (
        .clk      (clk_slow),
        .rst_n    (rst_n),
        .async_in (clk_stable),
        .sync_out (stable_sync)
    );

    otg_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk_slow),
        .rst_n   (rst_n),
        .run     (in_wait),
        .limit   (stable_timeout),
        .expired (wait_expired)
    );

    otg_pwr_fsm u_fsm (
        .clk            (clk_slow),
        .rst_n          (rst_n),
        .session_active (session_active),
        .evt_change     (evt_change),
        .sw_wake        (sw_wake),
        .clk_ok         (stable_sync),
        .wait_expired   (wait_expired),
        .irq_en         (wake_irq_en),
        .in_wait        (in_wait),
        .suspend        (suspend),
        .pll_on         (pll_en),
        .osc_on         (osc_en),
        .cp_on          (cp_en),
        .irq            (wake_irq)
    );

    assign hc_suspend = suspend;
    assign dc_suspend = suspend;
endmodule

// File: rtl/otg_pwr_sequencer_chk.sv
module otg_pwr_sequencer_chk (
    input logic clk_slow,
    input logic rst_n,
    input logic hc_suspend,
    input logic dc_suspend,
    input logic pll_en,
    input logic osc_en,
    input logic cp_en,
    input logic wake_irq
);
    // R2
    suspend_before_clkoff_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $fell(pll_en) |-> $past(hc_suspend && dc_suspend));

    // R3
    asleep_all_off_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !pll_en |-> (hc_suspend && dc_suspend && !osc_en && !cp_en));

    // R4
    restart_while_suspended_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $rose(pll_en) |-> (hc_suspend && dc_suspend && !cp_en));

    // R6
    release_after_clock_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $fell(hc_suspend) |-> ($past(pll_en) && pll_en && osc_en && cp_en));

    // R7
    irq_single_cycle_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        wake_irq |=> !wake_irq);

    // R7
    irq_when_awake_chk: assert property (@(posedge clk_slow) disable iff (!rst_n)
        wake_irq |-> (!hc_suspend && pll_en));
endmodule

bind otg_pwr_sequencer otg_pwr_sequencer_chk u_chk (
    .clk_slow   (clk_slow),
    .rst_n      (rst_n),
    .hc_suspend (hc_suspend),
    .dc_suspend (dc_suspend),
    .pll_en     (pll_en),
    .osc_en     (osc_en),
    .cp_en      (cp_en),
    .wake_irq   (wake_irq)
);

// File: tb/otg_pwr_sequencer_tb.sv
module otg_pwr_sequencer_tb_top;
    localparam int N_EVT = 3;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             session_active = 1'b1;
    logic [N_EVT-1:0] otg_evt = '0;
    logic             sw_wake = 1'b0;
    logic             clk_stable = 1'b0;
    logic             wake_irq_en = 1'b0;
    logic [CNT_W-1:0] stable_timeout = 8'd10;
    logic hc_suspend, dc_suspend, pll_en, osc_en, cp_en, wake_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    otg_pwr_sequencer #(.N_EVT(N_EVT), .CNT_W(CNT_W)) dut_i (
        .clk_slow       (clk),
        .rst_n          (rst_n),
        .session_active (session_active),
        .otg_evt        (otg_evt),
        .sw_wake        (sw_wake),
        .clk_stable     (clk_stable),
        .wake_irq_en    (wake_irq_en),
        .stable_timeout (stable_timeout),
        .hc_suspend     (hc_suspend),
        .dc_suspend     (dc_suspend),
        .pll_en         (pll_en),
        .osc_en         (osc_en),
        .cp_en          (cp_en),
        .wake_irq       (wake_irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_outs(input string req, input int susp, input int clkon, input int cp, input int irq);
        chk(req, "hc_suspend", int'(hc_suspend), susp);
        chk(req, "dc_suspend", int'(dc_suspend), susp);
        chk(req, "pll_en", int'(pll_en), clkon);
        chk(req, "osc_en", int'(osc_en), clkon);
        chk(req, "cp_en", int'(cp_en), cp);
        chk(req, "wake_irq", int'(wake_irq), irq);
    endtask

    // From RUN into POWER_DOWN; session comes back while asleep and must be ignored.
    task automatic enter_pd();
        session_active = 1'b0;
        tick(1);
        chk_outs("R2", 1, 1, 1, 0);
        tick(1);
        chk_outs("R2", 1, 0, 0, 0);
        session_active = 1'b1;
        tick(3);
        chk_outs("R3", 1, 0, 0, 0);
    endtask

    // From WAIT_CLK: report the clock stable and follow RESUME into RUN.
    task automatic finish_wake(input int en);
        clk_stable = 1'b1;
        tick(2);
        chk_outs("R6", 1, 1, 0, 0);
        tick(1);
        chk_outs("R7", 0, 1, 1, en);
        clk_stable = 1'b0;
        tick(1);
        chk_outs("R6", 0, 1, 1, 0);
    endtask

    initial begin
        tick(3);
        // R1: reset values
        chk_outs("R1", 0, 1, 1, 0);
        rst_n = 1'b1;
        tick(2);
        chk_outs("R1", 0, 1, 1, 0);

        // R9: wake causes in RUN have no effect
        otg_evt[0] = 1'b1;
        sw_wake = 1'b1;
        tick(1);
        sw_wake = 1'b0;
        tick(5);
        chk_outs("R9", 0, 1, 1, 0);

        // R4/R7: every event bit, both polarities, both interrupt settings
        for (int en = 0; en < 2; en++) begin
            for (int i = 0; i < N_EVT; i++) begin
                for (int d = 0; d < 2; d++) begin
                    enter_pd();  // held event levels do not wake (R9)
                    wake_irq_en = en[0];
                    otg_evt[i] = ~otg_evt[i];
                    tick(2);
                    chk_outs("R4", 1, 0, 0, 0);
                    tick(1);
                    chk_outs("R4", 1, 1, 0, 0);
                    finish_wake(en);
                end
            end
        end

        // R5: software wake with interrupt
        enter_pd();
        wake_irq_en = 1'b1;
        sw_wake = 1'b1;
        tick(1);
        sw_wake = 1'b0;
        chk_outs("R5", 1, 1, 0, 0);
        finish_wake(1);

        // R8: timeout sweep with the clock never stable
        enter_pd();
        for (int t = 0; t < 7; t++) begin
            int n;
            int irq_seen;
            stable_timeout = CNT_W'(t);
            sw_wake = 1'b1;
            tick(1);
            sw_wake = 1'b0;
            chk("R5", "pll_en after sw_wake", int'(pll_en), 1);
            n = 0;
            irq_seen = 0;
            do begin
                n++;
                tick(1);
                if (wake_irq || !hc_suspend) irq_seen = 1;
            end while (pll_en && n < 40);
            chk("R8", "wait cycles", n, (t < 1) ? 1 : t);
            chk("R8", "irq or release on timeout", irq_seen, 0);
            chk_outs("R8", 1, 0, 0, 0);
        end

        // R8: stable wins after a timeout-length window is configured
        stable_timeout = 8'd10;
        wake_irq_en = 1'b0;
        sw_wake = 1'b1;
        tick(1);
        sw_wake = 1'b0;
        finish_wake(0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule